// File: doc/BRIEF.md
# Interrupt Arbiter with One-Cycle Request Masking

This block merges five interrupt request sources into one arbitration decision for a small CPU core. Each request pulse sets a bit in a flag register. The CPU reads and writes that flag register and an enable register through a simple port. The pending set is the enabled, flagged bits, minus any bit whose request arrived in the previous cycle marked as "late". A late request is one raised off the cycle boundary, so it must stay hidden for exactly one cycle before it counts.

A non-empty pending set releases the CPU from its halted state, whatever the master enable says. At each instruction boundary the block may dispatch. It does so when the effective master enable is set and something is pending. It picks the lowest-numbered pending source, clears that flag bit and the master enable, and presents a one-cycle take strobe with the vector address.

An enable instruction turns the master enable on only after one further instruction boundary. A disable instruction turns it off at once.

Top module: `irq_arbiter`

## Requirements
- R1: After a synchronous reset, the enable register, flag bits, master enable, halted state and take strobe are all zero, and a flag read returns 0xE0.
- R2: A read with `rd_sel_i`=1 returns the flag register with bits 7:5 forced to 1. A read with `rd_sel_i`=0 returns the full 8-bit enable register. A write with `wr_sel_i`=1 replaces flag bits 4:0, and a write with `wr_sel_i`=0 replaces the enable register.
- R3: A request pulse on bit i sets flag bit i at the next edge. It wins over a same-cycle flag write or a same-cycle dispatch clear of that bit.
- R4: A request raised with its late bit set is excluded from the pending set during the cycle after it is flagged. Neither wake-up nor dispatch can see it until one cycle later.
- R5: `halted_o` is set by `halt_i` and is cleared at the next edge whenever the pending set is non-empty, regardless of the master enable.
- R6: A dispatch happens only in a cycle where `boundary_i` is high, the effective master enable is 1 and the pending set is non-empty.
- R7: The dispatched source is the lowest set bit of the pending set: bit 0 vertical blank, bit 1 display status, bit 2 timer, bit 3 serial, bit 4 joypad. `vec_o` = 0x40 + 8 × index.
- R8: A dispatch raises `take_o` for exactly one cycle after the deciding edge. At that same edge it clears the serviced flag bit and the master enable.
- R9: `ei_i` arms a toggle. The master enable becomes 1 at the next boundary, but that boundary still uses the old value for its decision. `di_i` clears both the enable and the toggle immediately and has priority over `ei_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request pulses, one per source |
| req_late_i | input | 5 | Marks the same-cycle request as off-boundary (hidden one cycle) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable, 1 flag |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 enable, 1 flag |
| rd_data_o | output | 8 | Read data |
| ei_i | input | 1 | Enable-instruction event (delayed enable) |
| di_i | input | 1 | Disable-instruction event (immediate) |
| boundary_i | input | 1 | Instruction boundary, dispatch opportunity |
| halt_i | input | 1 | CPU enters the halted state |
| halted_o | output | 1 | CPU is halted |
| ime_o | output | 1 | Master enable state |
| take_o | output | 1 | One-cycle dispatch strobe |
| take_idx_o | output | 3 | Index of the dispatched source |
| vec_o | output | 8 | Vector address of the dispatched source |

## Verification
The checker looks at every cycle. It confirms that any take follows a boundary with the master enable effective. It confirms the taken source was pending, was the lowest pending bit, and was not masked as late. It also confirms that a take drops the master enable, lasts one cycle, and that pending work always releases the halted state.

Other behaviours only the bench scenarios can show, measured against its reference model:
- the exact one-cycle lag of a late request,
- the deferred effect of the enable instruction,
- set-over-clear precedence on the flag bits,
- the exact vector values.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_FLAG   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] req_late_i,
  input  logic               wr_flag_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] late_o
);
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] late_q;
  logic [NUM_SRC-1:0] base_w;

  // A CPU write replaces the low bits; a clear is applied after it, and a set wins last.
  assign base_w = wr_flag_i ? wr_data_i[NUM_SRC-1:0] : flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      late_q <= '0;
    end else begin
      flag_q <= (base_w & ~clr_i) | req_i;
      // The mask lives for one cycle only, then frees the bit.
      late_q <= req_i & req_late_i;
    end
  end

  assign flag_o = flag_q;
  assign late_o = late_q;
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk,
  input  logic rst,
  input  logic ei_i,
  input  logic di_i,
  input  logic boundary_i,
  input  logic dispatch_i,
  output logic eff_o,
  output logic ime_o
);
  logic ime_q;
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ime_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      if (di_i || dispatch_i)        ime_q <= 1'b0;
      else if (boundary_i && tog_q)  ime_q <= 1'b1;

      if (di_i)            tog_q <= 1'b0;
      else if (ei_i)       tog_q <= 1'b1;
      else if (boundary_i) tog_q <= 1'b0;
    end
  end

  // The decision at a boundary uses the value held before the toggle lands.
  assign eff_o = ime_q;
  assign ime_o = ime_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] onehot_o
);
  logic [NUM_SRC:0] seen_w;
  assign seen_w[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign onehot_o[g]  = pend_i[g] & ~seen_w[g];
    assign seen_w[g+1]  = seen_w[g] | pend_i[g];
  end

  assign any_o = seen_w[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (onehot_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int          NUM_SRC   = 5,
  parameter int          DATA_W    = 8,
  parameter int          IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter logic [7:0]  VEC_BASE  = 8'h40,
  parameter int          VEC_SHIFT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] req_late_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_sel_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               boundary_i,
  input  logic               halt_i,
  output logic               halted_o,
  output logic               ime_o,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_idx_o,
  output logic [DATA_W-1:0]  vec_o
);
  import irq_arb_pkg::*;

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [DATA_W-1:0]  ie_q;
  logic [NUM_SRC-1:0] flag_w;
  logic [NUM_SRC-1:0] late_w;
  logic [NUM_SRC-1:0] pend_w;
  logic [NUM_SRC-1:0] onehot_w;
  logic [NUM_SRC-1:0] clr_w;
  logic [IDX_W-1:0]   pick_idx_w;
  logic               pick_any_w;
  logic               eff_ime_w;
  logic               dispatch_w;
  logic               wr_flag_w;
  logic               halted_q;
  logic               take_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DATA_W-1:0]  vec_q;

  assign wr_flag_w = wr_en_i && (wr_sel_i == SEL_FLAG);

  always_ff @(posedge clk) begin
    if (rst) ie_q <= '0;
    else if (wr_en_i && (wr_sel_i == SEL_ENABLE)) ie_q <= wr_data_i;
  end

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .req_late_i (req_late_i),
    .wr_flag_i  (wr_flag_w),
    .wr_data_i  (wr_data_i),
    .clr_i      (clr_w),
    .flag_o     (flag_w),
    .late_o     (late_w)
  );

  assign pend_w = ie_q[NUM_SRC-1:0] & flag_w & ~late_w;

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend_i   (pend_w),
    .any_o    (pick_any_w),
    .idx_o    (pick_idx_w),
    .onehot_o (onehot_w)
  );

  assign dispatch_w = boundary_i && eff_ime_w && pick_any_w;
  assign clr_w      = dispatch_w ? onehot_w : '0;

  irq_master_en u_ime (
    .clk        (clk),
    .rst        (rst),
    .ei_i       (ei_i),
    .di_i       (di_i),
    .boundary_i (boundary_i),
    .dispatch_i (dispatch_w),
    .eff_o      (eff_ime_w),
    .ime_o      (ime_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      take_q   <= 1'b0;
      idx_q    <= '0;
      vec_q    <= '0;
    end else begin
      halted_q <= (halted_q | halt_i) & ~pick_any_w;
      take_q   <= dispatch_w;
      if (dispatch_w) begin
        idx_q <= pick_idx_w;
        vec_q <= DATA_W'(VEC_BASE) + (DATA_W'(pick_idx_w) << VEC_SHIFT);
      end
    end
  end

  assign rd_data_o  = rd_sel_i ? {{PAD_W{1'b1}}, flag_w} : ie_q;
  assign halted_o   = halted_q;
  assign take_o     = take_q;
  assign take_idx_o = idx_q;
  assign vec_o      = vec_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               boundary_i,
  input logic               rd_sel_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               halted_o,
  input logic               ime_o,
  input logic               take_o,
  input logic [IDX_W-1:0]   take_idx_o,
  input logic [NUM_SRC-1:0] pend_w,
  input logic [NUM_SRC-1:0] late_w,
  input logic               eff_ime_w
);
  // R2
  flag_read_pad_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sel_i |-> (&rd_data_o[DATA_W-1:NUM_SRC]));

  // R5
  wake_on_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (|pend_w) |=> !halted_o);

  // R6
  take_needs_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ($past(boundary_i) && $past(eff_ime_w)));

  // R7
  take_was_pending_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((($past(pend_w) >> take_idx_o) & NUM_SRC'(1)) != '0));

  // R7
  take_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (($past(pend_w) & ((NUM_SRC'(1) << take_idx_o) - NUM_SRC'(1))) == '0));

  // R4
  take_not_late_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((($past(late_w) >> take_idx_o) & NUM_SRC'(1)) == '0));

  // R8
  take_drops_ime_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ime_o);

  // R8
  take_single_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .boundary_i (boundary_i),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .halted_o   (halted_o),
  .ime_o      (ime_o),
  .take_o     (take_o),
  .take_idx_o (take_idx_o),
  .pend_w     (pend_w),
  .late_w     (late_w),
  .eff_ime_w  (eff_ime_w)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] req_i, req_late_i;
  logic       wr_en_i, wr_sel_i, rd_sel_i;
  logic [7:0] wr_data_i;
  logic       ei_i, di_i, boundary_i, halt_i;
  logic [7:0] rd_data_o, vec_o;
  logic       halted_o, ime_o, take_o;
  logic [2:0] take_idx_o;

  always #4 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst(rst), .req_i(req_i), .req_late_i(req_late_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .ei_i(ei_i), .di_i(di_i),
    .boundary_i(boundary_i), .halt_i(halt_i), .halted_o(halted_o),
    .ime_o(ime_o), .take_o(take_o), .take_idx_o(take_idx_o), .vec_o(vec_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cyc    = 0;

  // reference model state
  logic [7:0] m_ie;
  logic [4:0] m_if, m_late;
  logic       m_ime, m_tog, m_halt, m_take;
  logic [2:0] m_idx;
  logic [7:0] m_vec;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic model_update();
    logic [4:0] pend;
    logic       disp;
    logic [4:0] nf;
    int         k;
    if (rst) begin
      m_ie = 0; m_if = 0; m_late = 0; m_ime = 0; m_tog = 0;
      m_halt = 0; m_take = 0; m_idx = 0; m_vec = 0;
      return;
    end
    pend = m_ie[4:0] & m_if & ~m_late;
    disp = boundary_i && m_ime && (pend != 0);
    k    = lowest(pend);
    nf   = (wr_en_i && wr_sel_i) ? wr_data_i[4:0] : m_if;
    if (disp) nf[k] = 1'b0;
    m_if   = nf | req_i;
    if (wr_en_i && !wr_sel_i) m_ie = wr_data_i;
    m_late = req_i & req_late_i;
    if (di_i || disp) m_ime = 0;
    else if (boundary_i && m_tog) m_ime = 1;
    if (di_i) m_tog = 0;
    else if (ei_i) m_tog = 1;
    else if (boundary_i) m_tog = 0;
    m_halt = (m_halt | halt_i) && (pend == 0);
    m_take = disp;
    if (disp) begin
      m_idx = 3'(k);
      m_vec = 8'h40 + 8'(k * 8);
    end
  endtask

  task automatic compare();
    chk("R8 take strobe", int'(take_o), int'(m_take));
    if (m_take) begin
      chk("R7 vector", int'(vec_o), int'(m_vec));
      chk("R7 index", int'(take_idx_o), int'(m_idx));
    end
    chk("R5 halted", int'(halted_o), int'(m_halt));
    chk("R9 master enable", int'(ime_o), int'(m_ime));
    if (rd_sel_i) chk("R2 flag read", int'(rd_data_o), int'({3'b111, m_if}));
    else          chk("R2 enable read", int'(rd_data_o), int'(m_ie));
  endtask

  task automatic idle();
    req_i = 0; req_late_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0;
    ei_i = 0; di_i = 0; boundary_i = 0; halt_i = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_update();
    @(negedge clk);
    if (!done) compare();
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    idle(); wr_en_i = 1; wr_sel_i = sel; wr_data_i = d; step(); idle();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20170902));
    idle(); rd_sel_i = 1; rst = 1;
    step(); step();
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag read after reset", int'(rd_data_o), 'hE0);
    chk("R1 take after reset", int'(take_o), 0);
    chk("R1 ime after reset", int'(ime_o), 0);
    chk("R1 halted after reset", int'(halted_o), 0);
    rd_sel_i = 0; #1;
    chk("R1 enable after reset", int'(rd_data_o), 0);

    // R2 register access
    wr(0, 8'hA1);
    chk("R2 enable readback", int'(rd_data_o), 'hA1);
    rd_sel_i = 1;
    wr(1, 8'h0A);
    chk("R2 flag write replaces low bits", int'(rd_data_o), 'hEA);

    // R3 request beats same-cycle write of zero
    idle(); wr_en_i = 1; wr_sel_i = 1; wr_data_i = 0; req_i = 5'b01000; step(); idle();
    chk("R3 set wins over write", int'(rd_data_o), 'hE8);
    wr(1, 8'h00);

    // R9 delayed enable
    wr(0, 8'h1F);
    idle(); ei_i = 1; step(); idle();
    chk("R9 ime not yet on", int'(ime_o), 0);
    boundary_i = 1; step(); idle();
    chk("R9 ime on after boundary", int'(ime_o), 1);

    // R4 late request hidden one cycle
    req_i = 5'b00001; req_late_i = 5'b00001; step(); idle();
    boundary_i = 1; step();
    chk("R4 late request not taken", int'(take_o), 0);
    step(); idle();
    chk("R4 late request taken one cycle later", int'(take_o), 1);
    chk("R7 vblank vector", int'(vec_o), 'h40);
    chk("R8 flag bit cleared", int'(rd_data_o), 'hE0);
    chk("R8 ime cleared", int'(ime_o), 0);

    // R7 priority among timer and joypad, R6 no take without ime
    wr(1, 8'h14);
    boundary_i = 1; step(); idle();
    chk("R6 no take with ime off", int'(take_o), 0);
    chk("R5 halted stays clear", int'(halted_o), 0);
    ei_i = 1; step(); idle();
    boundary_i = 1; step(); step(); idle();
    chk("R7 timer beats joypad", int'(vec_o), 'h50);
    chk("R8 only timer cleared", int'(rd_data_o), 'hF0);

    // R5 halt released by pending without ime
    wr(1, 8'h00);
    halt_i = 1; step(); idle();
    chk("R5 halted set", int'(halted_o), 1);
    step();
    chk("R5 halted held", int'(halted_o), 1);
    req_i = 5'b00010; req_late_i = 5'b00010; step(); idle();
    step();
    chk("R4 wake lags late request", int'(halted_o), 1);
    step();
    chk("R5 wake after mask expires", int'(halted_o), 0);

    // random phase against the reference model (all requirements)
    for (int n = 0; n < 4000; n++) begin
      req_i      = 5'($urandom) & 5'($urandom) & 5'($urandom);
      req_late_i = 5'($urandom);
      wr_en_i    = ($urandom % 10) == 0;
      wr_sel_i   = 1'($urandom);
      wr_data_i  = 8'($urandom);
      rd_sel_i   = 1'($urandom);
      ei_i       = ($urandom % 6) == 0;
      di_i       = ($urandom % 20) == 0;
      boundary_i = 1'($urandom);
      halt_i     = ($urandom % 12) == 0;
      step();
    end
    idle();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule